// File: doc/BRIEF.md
# Serial Two-of-Three Vote Detector

This block watches a serial bit stream that arrives one bit per clock and reports, on every cycle, whether at least two of the three most recently captured bits were 1. It is a Moore machine. Its state is simply the last three input bits, so the next state is a plain shift of the history and the output is a three-input majority of that history.

The block has no reset pin. Its state registers carry initial values, so the machine starts as if only zeros had been received and the output starts at 0. Two elaboration options choose how the vote is built. The first picks a sum-of-products gate or a population count. The second picks whether the output is decoded from the history register or held in a flop of its own that is loaded with the vote of the incoming history. In every combination the output has the same timing and the same values.

Top module: `serial_vote3`

## Requirements
- R1: At power-up, before any clock edge, `vote_o` is 0, and the machine behaves as if the three previous bits were all 0.
- R2: After the rising edge that captures bit k, `vote_o` is 1 exactly when at least two of bits k, k-1 and k-2 are 1. Bits that were never captured count as 0.
- R3: `vote_o` depends only on the captured history. A change on `bit_i` between rising edges leaves `vote_o` unchanged until the next rising edge.
- R4: Starting from power-up, the input stream 00010100110101100 (first bit leftmost, one bit per edge) yields the output stream 00000100011101110, where each output bit is the value after the edge that captures the input bit in the same position.
- R5: A bit older than the three most recent has no effect. For example, 1,1,0,0 gives 0 after the last edge, and 1,0,0,1 gives 0 after the last edge.
- R6: The two vote options (VOTE_IMPL 0 = sum of products, 1 = population count) and the two output options (OUT_REG 0 = decoded from state, 1 = output flop) give identical `vote_o` sequences for the same input.
- R7: A parameter value outside its allowed set (VOTE_IMPL or OUT_REG not 0 or 1) stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; `bit_i` is captured on the rising edge |
| bit_i | input | 1 | Serial data bit |
| vote_o | output | 1 | 1 when at least two of the last three captured bits are 1 |

## Verification
Every result is due one rising edge after the bit that causes it. A new bit reaches the history register on that edge, and the vote follows either without a further register or through an output flop loaded in the same edge. The bench therefore drives each bit at a falling edge and compares `vote_o` at the next falling edge, half a period after the capturing edge. For the Moore check the bench changes `bit_i` mid-cycle and samples `vote_o` before the next rising edge, where it must still show the earlier value. The bench sweeps every six-bit pattern after a zero flush and then runs a long pseudo-random stream, with a second instance built from the other two options compared on the same cycles.

// File: rtl/ser_vote_pkg.sv
package ser_vote_pkg;
   // Depth of the bit history and the number of ones that make a vote.
   localparam int HIST_W   = 3;
   localparam int VOTE_MIN = 2;
   localparam int CNT_W    = $clog2(HIST_W + 1);

   typedef logic [HIST_W-1:0] hist_t;

   // Variant codes for the vote gate.
   localparam int VOTE_SOP = 0;
   localparam int VOTE_CNT = 1;
endpackage

// File: rtl/ser_hist_shift.sv
module ser_hist_shift
   import ser_vote_pkg::*;
(
   input  logic  clk_i,
   input  logic  bit_i,
   output hist_t hist_o,   // bit 0 is the newest captured bit
   output hist_t next_o    // history after the coming edge
);
   // The initial value stands in for a reset: all zeros seen.
   hist_t hist_q = '0;

   assign next_o = {hist_q[HIST_W-2:0], bit_i};

   always_ff @(posedge clk_i) begin
      hist_q <= next_o;
   end

   assign hist_o = hist_q;

   logic chk_armed_q = 1'b0;
   always_ff @(posedge clk_i) chk_armed_q <= 1'b1;

   // R2
   newest_bit_chk: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
      1'b1 |=> hist_o[0] == $past(bit_i));

   // R5
   older_shift_chk: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
      1'b1 |=> hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0]));
endmodule

// File: rtl/ser_vote_gate.sv
module ser_vote_gate
   import ser_vote_pkg::*;
#(
   parameter int VOTE_IMPL = VOTE_SOP
) (
   input  hist_t hist_i,
   output logic  vote_o
);
   generate
      if (VOTE_IMPL == VOTE_SOP) begin : g_sop
         // Majority written as the three pairwise products.
         assign vote_o = (hist_i[0] & hist_i[1])
                       | (hist_i[1] & hist_i[2])
                       | (hist_i[0] & hist_i[2]);
      end else begin : g_cnt
         logic [CNT_W-1:0] ones;
         always_comb begin
            ones = '0;
            for (int i = 0; i < HIST_W; i++) begin
               ones = ones + CNT_W'(hist_i[i]);
            end
         end
         assign vote_o = (ones >= CNT_W'(VOTE_MIN));
      end
   endgenerate

   // R2
   always_comb begin
      vote_count_chk: assert (vote_o == ($countones(hist_i) >= VOTE_MIN));
   end
endmodule

// File: rtl/serial_vote3.sv
module serial_vote3
   import ser_vote_pkg::*;
#(
   parameter int VOTE_IMPL = VOTE_SOP,  // 0 sum of products, 1 population count
   parameter int OUT_REG   = 0          // 0 decode from state, 1 output flop
) (
   input  logic clk_i,
   input  logic bit_i,
   output logic vote_o
);
   // R7
   generate
      if (VOTE_IMPL != VOTE_SOP && VOTE_IMPL != VOTE_CNT) begin : g_bad_impl
         $error("serial_vote3: VOTE_IMPL must be 0 or 1");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_oreg
         $error("serial_vote3: OUT_REG must be 0 or 1");
      end
      if (HIST_W != 3) begin : g_bad_hist
         $error("serial_vote3: history depth must be 3");
      end
   endgenerate

   hist_t hist_q;
   hist_t hist_next;

   ser_hist_shift u_hist (
      .clk_i  (clk_i),
      .bit_i  (bit_i),
      .hist_o (hist_q),
      .next_o (hist_next)
   );

   generate
      if (OUT_REG == 0) begin : g_dec
         ser_vote_gate #(.VOTE_IMPL(VOTE_IMPL)) u_gate (
            .hist_i (hist_q),
            .vote_o (vote_o)
         );
      end else begin : g_flop
         logic vote_next;
         logic vote_q = 1'b0;
         ser_vote_gate #(.VOTE_IMPL(VOTE_IMPL)) u_gate (
            .hist_i (hist_next),
            .vote_o (vote_next)
         );
         always_ff @(posedge clk_i) begin
            vote_q <= vote_next;
         end
         assign vote_o = vote_q;
      end
   endgenerate

   logic chk_armed_q = 1'b0;
   always_ff @(posedge clk_i) chk_armed_q <= 1'b1;

   // R1
   always_comb begin
      if (!chk_armed_q) begin
         start_zero_chk: assert (vote_o == 1'b0 || hist_q != '0);
      end
   end

   // R2
   pair_raises_chk: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
      (bit_i && hist_q[0]) |=> vote_o);

   // R2
   history_step_chk: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
      1'b1 |=> hist_q == $past(hist_next));

   // R3
   moore_hold_chk: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
      $stable(hist_q) |-> $stable(vote_o));

   // R5
   lone_one_chk: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
      (!bit_i && !hist_q[0]) |=> !vote_o);
endmodule

// File: tb/serial_vote3_tb.sv
`timescale 1ns/1ps
module serial_vote3_tb_top;
   logic clk = 1'b0;
   logic bit_r = 1'b0;
   logic vote_w;
   logic vote_alt_w;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [2:0] hist_m = 3'b000;

   always #5 clk = ~clk;

   serial_vote3 #(.VOTE_IMPL(0), .OUT_REG(0)) dut_i (
      .clk_i (clk), .bit_i (bit_r), .vote_o (vote_w));

   serial_vote3 #(.VOTE_IMPL(1), .OUT_REG(1)) alt_i (
      .clk_i (clk), .bit_i (bit_r), .vote_o (vote_alt_w));

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: got %b expected %b", tag, cycles, act, exp);
      end
   endtask

   function automatic logic vote_of(input logic [2:0] h);
      int n = 0;
      for (int i = 0; i < 3; i++) n += int'(h[i]);
      return n >= 2;
   endfunction

   // Drive at a falling edge, capture on the rising edge, check at the next falling edge.
   task automatic push(input logic b, input string tag);
      bit_r = b;
      @(posedge clk);
      hist_m = {hist_m[1:0], b};
      @(negedge clk);
      check(vote_w, vote_of(hist_m), tag);
      check(vote_alt_w, vote_w, "R6");
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) push(1'b0, "R5");
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [16:0] seq_in  = 17'b00010100110101100;
      logic [16:0] seq_out = 17'b00000100011101110;

      // R1: before the first edge
      #1;
      check(vote_w, 1'b0, "R1");
      check(vote_alt_w, 1'b0, "R1");
      @(negedge clk);

      // R4: the given stream from power-up
      for (int i = 16; i >= 0; i--) begin
         push(seq_in[i], "R2");
         check(vote_w, seq_out[i], "R4");
      end

      // R5: stale ones are forgotten
      flush();
      push(1'b1, "R5"); push(1'b1, "R5"); push(1'b0, "R5"); push(1'b0, "R5");
      check(vote_w, 1'b0, "R5");
      push(1'b1, "R5"); push(1'b0, "R5"); push(1'b0, "R5"); push(1'b1, "R5");
      check(vote_w, 1'b0, "R5");

      // R2: every six-bit pattern after a zero flush
      for (int p = 0; p < 64; p++) begin
         flush();
         for (int j = 5; j >= 0; j--) push(p[j], "R2");
      end

      // R3: mid-cycle input changes do not reach the output
      for (int k = 0; k < 8; k++) begin
         logic held;
         push(k[0] | k[1], "R2");
         held = vote_w;
         bit_r = 1'b1;
         #1;
         check(vote_w, held, "R3");
         bit_r = 1'b0;
         #1;
         check(vote_w, held, "R3");
         bit_r = 1'b1;
         #1;
         check(vote_w, held, "R3");
         check(vote_alt_w, held, "R3");
      end

      // R2 and R6: pseudo-random stream
      for (int r = 0; r < 3000; r++) push(1'($urandom_range(0, 1)), "R2");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule